// File: doc/BRIEF.md
# Parameterized Flat Look-Ahead Binary Adder

This block adds two unsigned operands of configurable width and a one-bit carry input. It has no clock and no stored state. Every bit pair goes through its own half-adder cell, which yields a generate term (both bits set) and a propagate term (exactly one bit set). These terms do not go to the next bit. They all go to one look-ahead carry unit, which works out each carry as a two-level sum of products taken straight from the generate and propagate terms and the carry input. No carry signal feeds the calculation of another carry, so the logic depth of the carry path stays flat as the width grows.

A final stage XORs each propagate term with the carry into that bit to form the sum. The carry out of the top bit becomes the block's carry output, which can serve as an unsigned overflow flag. The carry input is normally held low. Driving it high adds one to the sum.

Top module: `claAdder`

## Requirements
- R1: `sumOut` equals (`opA` + `opB` + `carryIn`) modulo 2^WIDTH for every input combination.
- R2: `carryOut` equals bit WIDTH of the full (WIDTH+1)-bit sum `opA` + `opB` + `carryIn`.
- R3: `carryIn` enters at bit 0 with weight one: with both operands zero and `carryIn` = 1, `sumOut` is 1 and `carryOut` is 0.
- R4: With `opA` all ones, `opB` = 1 and `carryIn` = 0, `sumOut` is all zeros and `carryOut` is 1.
- R5: When `opB` is the bitwise inverse of `opA`, a carry input of 1 travels through every bit: `sumOut` is all zeros and `carryOut` is 1. With a carry input of 0, `sumOut` is all ones and `carryOut` is 0.
- R6: With both operands zero and `carryIn` = 0, `sumOut` and `carryOut` are both zero.
- R7: Swapping `opA` and `opB` leaves `sumOut` and `carryOut` unchanged.
- R8: The results of R1 and R2 hold for any WIDTH of at least 1, including widths that are not a power of two, such as 5.
- R9: `carryOut` agrees with the top bits: it is 1 exactly when both operand MSBs are 1, or when exactly one operand MSB is 1 and the sum MSB is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Sum modulo 2^WIDTH |
| carryOut | output | 1 | Carry out of the most significant bit |

## Verification
Two effects can fall on the same input vector. One is a carry produced by a generate term at a low bit. The other is a carry input that has to pass through a long run of propagate terms. The bench triggers both by sweeping all operand pairs at 5 and 8 bits with both carry-input values, by forcing complementary operands (propagate set at every bit) at 8, 16 and 32 bits, and by random vectors at the wider sizes. For every vector, the concatenation of carry output and sum is compared with an arithmetic sum the bench computes itself.

// File: rtl/claPkg.sv
package claPkg;
  // Output pair of one half-adder cell
  typedef struct packed {
    logic gen;   // both input bits set
    logic prop;  // exactly one input bit set
  } bitPairT;
endpackage

// File: rtl/claHalfAdder.sv
module claHalfAdder
  import claPkg::*;
(
  input  logic    aBit,
  input  logic    bBit,
  output bitPairT pairOut
);
  assign pairOut.gen  = aBit & bBit;
  assign pairOut.prop = aBit ^ bBit;
endmodule

// File: rtl/claCarryUnit.sv
module claCarryUnit #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] genVec,
  input  logic [WIDTH-1:0] propVec,
  input  logic             carryIn,
  output logic [WIDTH:0]   carryVec
);
  assign carryVec[0] = carryIn;

  // Every carry is built from the g/p terms and carryIn alone.
  for (genvar i = 0; i < WIDTH; i++) begin : g_carry
    logic termOr;
    always_comb begin
      logic prod;
      termOr = 1'b0;
      for (int j = 0; j <= i; j++) begin
        prod = genVec[j];
        for (int k = j + 1; k <= i; k++) begin
          prod = prod & propVec[k];
        end
        termOr = termOr | prod;
      end
      prod = carryIn;
      for (int k = 0; k <= i; k++) begin
        prod = prod & propVec[k];
      end
      termOr = termOr | prod;
    end
    assign carryVec[i+1] = termOr;
  end
endmodule

// File: rtl/claSumStage.sv
module claSumStage #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] propVec,
  input  logic [WIDTH:0]   carryVec,
  output logic [WIDTH-1:0] sumVec,
  output logic             carryTop
);
  assign sumVec   = propVec ^ carryVec[WIDTH-1:0];
  assign carryTop = carryVec[WIDTH];
endmodule

// File: rtl/claAdder.sv
module claAdder
  import claPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  bitPairT          pairVec [WIDTH];
  logic [WIDTH-1:0] genVec;
  logic [WIDTH-1:0] propVec;
  logic [WIDTH:0]   carryVec;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    claHalfAdder i_cell (
      .aBit    (opA[i]),
      .bBit    (opB[i]),
      .pairOut (pairVec[i])
    );
    assign genVec[i]  = pairVec[i].gen;
    assign propVec[i] = pairVec[i].prop;
  end

  claCarryUnit #(.WIDTH(WIDTH)) i_carry (
    .genVec   (genVec),
    .propVec  (propVec),
    .carryIn  (carryIn),
    .carryVec (carryVec)
  );

  claSumStage #(.WIDTH(WIDTH)) i_sum (
    .propVec  (propVec),
    .carryVec (carryVec),
    .sumVec   (sumOut),
    .carryTop (carryOut)
  );
endmodule

// File: rtl/claAdderChk.sv
module claAdderChk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut
);
  logic [WIDTH:0] fullSum;
  assign fullSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    // R1 R2 R8
    sum_value_chk: assert ({carryOut, sumOut} == fullSum);
    // R5
    prop_chain_chk: assert (!(opA == ~opB) ||
                            (carryOut == carryIn && sumOut == {WIDTH{~carryIn}}));
    // R6 R3
    zero_ops_chk: assert (!(opA == '0 && opB == '0) ||
                          (carryOut == 1'b0 && sumOut == {{(WIDTH-1){1'b0}}, carryIn}));
    // R9
    msb_carry_chk: assert (carryOut == ((opA[WIDTH-1] & opB[WIDTH-1]) |
                           ((opA[WIDTH-1] ^ opB[WIDTH-1]) & ~sumOut[WIDTH-1])));
  end
endmodule

bind claAdder claAdderChk #(.WIDTH(WIDTH)) i_claAdderChk (
  .opA      (opA),
  .opB      (opB),
  .carryIn  (carryIn),
  .sumOut   (sumOut),
  .carryOut (carryOut)
);

// File: tb/test_claAdder.sv
module test_claAdder;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [4:0]  a5, b5, s5;   logic c5, co5;
  logic [7:0]  a8, b8, s8;   logic c8, co8;
  logic [15:0] a16, b16, s16; logic c16, co16;
  logic [31:0] a32, b32, s32; logic c32, co32;

  claAdder #(.WIDTH(5))  i_claAdder5  (.opA(a5),  .opB(b5),  .carryIn(c5),  .sumOut(s5),  .carryOut(co5));
  claAdder #(.WIDTH(8))  i_claAdder   (.opA(a8),  .opB(b8),  .carryIn(c8),  .sumOut(s8),  .carryOut(co8));
  claAdder #(.WIDTH(16)) i_claAdder16 (.opA(a16), .opB(b16), .carryIn(c16), .sumOut(s16), .carryOut(co16));
  claAdder #(.WIDTH(32)) i_claAdder32 (.opA(a32), .opB(b32), .carryIn(c32), .sumOut(s32), .carryOut(co32));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run8(input logic [7:0] a, input logic [7:0] b, input logic c, input string req);
    logic [8:0] e;
    a8 = a; b8 = b; c8 = c;
    #1;
    e = {1'b0, a} + {1'b0, b} + {8'd0, c};
    check(req, {55'd0, co8, s8}, {55'd0, e});
  endtask

  task automatic run16(input logic [15:0] a, input logic [15:0] b, input logic c, input string req);
    logic [16:0] e;
    a16 = a; b16 = b; c16 = c;
    #1;
    e = {1'b0, a} + {1'b0, b} + {16'd0, c};
    check(req, {47'd0, co16, s16}, {47'd0, e});
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b, input logic c, input string req);
    logic [32:0] e;
    a32 = a; b32 = b; c32 = c;
    #1;
    e = {1'b0, a} + {1'b0, b} + {32'd0, c};
    check(req, {31'd0, co32, s32}, {31'd0, e});
  endtask

  initial begin
    a5 = '0; b5 = '0; c5 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a16 = '0; b16 = '0; c16 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    #1;
    // R6 initial zero state at all widths
    check("R6 zero 8", {55'd0, co8, s8}, 64'd0);
    check("R6 zero 16", {47'd0, co16, s16}, 64'd0);
    check("R6 zero 32", {31'd0, co32, s32}, 64'd0);
    check("R6 zero 5", {58'd0, co5, s5}, 64'd0);

    // R3 carry-in weight one
    run8(8'h00, 8'h00, 1'b1, "R3 cin only 8");
    run32(32'h0, 32'h0, 1'b1, "R3 cin only 32");
    // R4 all ones plus one
    run8(8'hFF, 8'h01, 1'b0, "R4 wrap 8");
    check("R4 carry 8", {63'd0, co8}, 64'd1);
    run16(16'hFFFF, 16'h0001, 1'b0, "R4 wrap 16");
    run32(32'hFFFF_FFFF, 32'h1, 1'b0, "R4 wrap 32");
    // R5 full propagate chains
    run8(8'hA5, 8'h5A, 1'b1, "R5 chain cin1 8");
    run8(8'hA5, 8'h5A, 1'b0, "R5 chain cin0 8");
    run16(16'h1234, ~16'h1234, 1'b1, "R5 chain cin1 16");
    run32(32'hDEAD_BEEF, ~32'hDEAD_BEEF, 1'b1, "R5 chain cin1 32");
    check("R5 sum zero 32", {32'd0, s32}, 64'd0);
    run32(32'h0F0F_0F0F, ~32'h0F0F_0F0F, 1'b0, "R5 chain cin0 32");
    check("R5 sum ones 32", {32'd0, s32}, {32'd0, 32'hFFFF_FFFF});

    // R1 R2 exhaustive at 8 bits
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++)
          run8(a[7:0], b[7:0], c[0], "R1 R2 sweep 8");

    // R8 exhaustive at a non-power-of-two width
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++)
        for (int c = 0; c < 2; c++) begin
          logic [5:0] e;
          a5 = a[4:0]; b5 = b[4:0]; c5 = c[0];
          #1;
          e = {1'b0, a5} + {1'b0, b5} + {5'd0, c5};
          check("R8 sweep 5", {58'd0, co5, s5}, {58'd0, e});
        end

    // R1 R2 random at wider sizes, R7 swap
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] ra, rb;
      logic rc;
      logic [32:0] keep;
      ra = $urandom; rb = $urandom; rc = 1'($urandom);
      run16(ra[15:0], rb[15:0], rc, "R1 R2 random 16");
      run32(ra, rb, rc, "R1 R2 random 32");
      keep = {co32, s32};
      run32(rb, ra, rc, "R7 swapped 32");
      check("R7 swap equal 32", {31'd0, co32, s32}, {31'd0, keep});
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule